// File: doc/BRIEF.md
# Synchronous-Rectifier Gate Supervisor

This block decides whether the secondary-side rectifier gate drivers may switch. It watches two things. The first is how long the rectifier conducts in each switching cycle, which tells it when the converter is at light load. The second is a set of fault flags from analog comparators. It drops a single gate-enable when either a light-load (green) condition or a fault calls for it.

Conduction durations arrive as a stream. Each accepted beat is one switching cycle, and its length is measured in clock ticks. The default timings assume a 100 MHz clock. The stream has a valid/ready pair, but the block never applies back-pressure. Ready is high whenever the block is out of reset, so every beat offered on a clock edge is consumed on that edge. A source therefore never needs to hold a beat.

The fault flags are plain level inputs. The comparators, threshold generation and soft-start shaping are outside this block. Fault codes use the encoding 0 none, 1 program-pin short, 2 program-pin open, 3 output short, 4 supply over-voltage, 5 over-temperature.

Top module: `srgate_supervisor`

## Requirements
- R1: Out of reset, gate_en is 1, green is 0, fault_code is 0 and cyc_ready is 1.
- R2: While not green, seven consecutive accepted beats with cyc_len strictly below the threshold set green to 1 on the edge that accepts the seventh. The threshold is 375 ticks when hf_sel is 0 and 190 ticks when hf_sel is 1.
- R3: While green, seven consecutive accepted beats with cyc_len strictly above the same threshold clear green on the edge that accepts the seventh.
- R4: An accepted beat that does not qualify restarts the qualifying count from zero. A length equal to the threshold never qualifies.
- R5: det_high sampled high on 2400 consecutive edges sets green on the 2400th edge and clears the qualifying count.
- R6: When the burst entry of R5 and the seventh exit beat of R3 land on the same edge, burst wins and green stays 1.
- R7: pin_short or pin_open sampled high on 200 consecutive edges latches code 1 or code 2, respectively. The code holds until reset, even after the flag drops. A shorter run has no effect.
- R8: out_short sampled high on 1600 consecutive edges latches code 3 until reset.
- R9: ov_flag sampled high on 6000 consecutive edges raises code 4. The fault releases on the first edge that samples ov_flag low.
- R10: ot_set raises code 5 on the next edge. The fault releases only on an edge where ot_clr is high and ot_set is low.
- R11: When several faults are active, fault_code shows the lowest code among them.
- R12: gate_en is 1 exactly when fault_code is 0 and green is 0. cyc_ready stays 1 outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | A conduction-duration beat is offered |
| cyc_ready | output | 1 | Beat accepted (high outside reset) |
| cyc_len | input | LEN_W | Conduction duration of the cycle, in ticks |
| det_high | input | 1 | Drain detect is high (no conduction) |
| hf_sel | input | 1 | 1 selects the high-frequency threshold |
| pin_short | input | 1 | Program-pin voltage below the short limit |
| pin_open | input | 1 | Program-pin voltage above the open limit |
| out_short | input | 1 | Feedback indicates an output short |
| ov_flag | input | 1 | Supply above the over-voltage limit (hysteresis applied outside) |
| ot_set | input | 1 | Die temperature above the shutdown limit |
| ot_clr | input | 1 | Die temperature below the restart limit |
| gate_en | output | 1 | Rectifier gates may switch |
| green | output | 1 | Light-load mode active |
| fault_code | output | 3 | Active fault code, lowest code first |

## Verification
Two collisions get the most attention.

The first is green-mode exit against burst entry. The bench counts six long beats into an exit and then holds det_high so that its 2400th high edge carries the seventh long beat. The bench expects green to stay set. It also expects the qualifying count to be cleared, so that a further six long beats still leave green set and only the seventh clears it.

The second collision is between fault sources. The bench raises two sources in overlapping windows: over-temperature during an over-voltage fault, and pin-open during a latched pin-short. Each time it checks that fault_code keeps the lower code. After the lower fault releases, it checks that the higher code appears. A behavioural model in the bench repeats this comparison on every clock.

// File: rtl/srsup_pkg.sv
package srsup_pkg;
  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_PIN_LO    = 3'd1,
    FLT_PIN_HI    = 3'd2,
    FLT_OUT_SHORT = 3'd3,
    FLT_OVERVOLT  = 3'd4,
    FLT_OVERTEMP  = 3'd5
  } fault_e;
endpackage

// File: rtl/srsup_persist.sv
// Persistence timer: fire pulses once when level has been sampled high
// on TICKS consecutive edges.
module srsup_persist #(
  parameter int TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fire
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  localparam logic [CW-1:0] FULL = CW'(TICKS);

  logic [CW-1:0] run_cnt;

  assign fire = level && (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)             run_cnt <= '0;
    else if (!level)        run_cnt <= '0;
    else if (run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
  end

  // R7: a persistence fire is a single pulse per high run
  assert_fire_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/srsup_green.sv
// Light-load mode detector: cycle-count entry/exit plus burst timeout.
module srsup_green #(
  parameter int LEN_W       = 12,
  parameter int THR_LF      = 375,
  parameter int THR_HF      = 190,
  parameter int QUAL_N      = 7,
  parameter int BURST_TICKS = 2400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_valid,
  input  logic [LEN_W-1:0] cyc_len,
  input  logic             hf_sel,
  input  logic             det_high,
  output logic             green
);
  localparam int QW = $clog2(QUAL_N + 1);
  localparam logic [LEN_W-1:0] THR_L = LEN_W'(THR_LF);
  localparam logic [LEN_W-1:0] THR_H = LEN_W'(THR_HF);
  localparam logic [QW-1:0]    Q_LAST = QW'(QUAL_N - 1);

  logic [QW-1:0]    qual_cnt;
  logic [LEN_W-1:0] thr;
  logic             qualifies;
  logic             burst_fire;

  srsup_persist #(.TICKS(BURST_TICKS)) u_burst (
    .clk(clk), .rst_n(rst_n), .level(det_high), .fire(burst_fire)
  );

  always_comb begin
    thr       = hf_sel ? THR_H : THR_L;
    qualifies = green ? (cyc_len > thr) : (cyc_len < thr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      green    <= 1'b0;
      qual_cnt <= '0;
    end else if (burst_fire) begin
      green    <= 1'b1;
      qual_cnt <= '0;
    end else if (cyc_valid) begin
      if (!qualifies) begin
        qual_cnt <= '0;
      end else if (qual_cnt == Q_LAST) begin
        green    <= !green;
        qual_cnt <= '0;
      end else begin
        qual_cnt <= qual_cnt + 1'b1;
      end
    end
  end

  // R2: green only changes in response to a beat or a burst timeout
  assert_green_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(green) |-> $past(cyc_valid || burst_fire));
  // R4: a rejected beat restarts the count
  assert_reject_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !qualifies && !burst_fire) |=> (qual_cnt == '0));
  // R6: burst timeout always leaves green set
  assert_burst_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_fire |=> green);
endmodule

// File: rtl/srsup_faults.sv
// Debounced fault monitors and priority encoder.
module srsup_faults
  import srsup_pkg::*;
#(
  parameter int PIN_TICKS   = 200,
  parameter int SHORT_TICKS = 1600,
  parameter int OV_TICKS    = 6000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_short,
  input  logic       pin_open,
  input  logic       out_short,
  input  logic       ov_flag,
  input  logic       ot_set,
  input  logic       ot_clr,
  output logic [2:0] code
);
  logic fire_ps, fire_po, fire_os, fire_ov;
  logic lat_ps, lat_po, lat_os, ov_act, ot_act;
  fault_e code_e;

  srsup_persist #(.TICKS(PIN_TICKS)) u_ps (
    .clk(clk), .rst_n(rst_n), .level(pin_short), .fire(fire_ps));
  srsup_persist #(.TICKS(PIN_TICKS)) u_po (
    .clk(clk), .rst_n(rst_n), .level(pin_open), .fire(fire_po));
  srsup_persist #(.TICKS(SHORT_TICKS)) u_os (
    .clk(clk), .rst_n(rst_n), .level(out_short), .fire(fire_os));
  srsup_persist #(.TICKS(OV_TICKS)) u_ov (
    .clk(clk), .rst_n(rst_n), .level(ov_flag), .fire(fire_ov));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_ps <= 1'b0;
      lat_po <= 1'b0;
      lat_os <= 1'b0;
      ov_act <= 1'b0;
      ot_act <= 1'b0;
    end else begin
      lat_ps <= lat_ps | fire_ps;
      lat_po <= lat_po | fire_po;
      lat_os <= lat_os | fire_os;
      if (fire_ov)       ov_act <= 1'b1;
      else if (!ov_flag) ov_act <= 1'b0;
      if (ot_set)        ot_act <= 1'b1;
      else if (ot_clr)   ot_act <= 1'b0;
    end
  end

  always_comb begin
    if (lat_ps)      code_e = FLT_PIN_LO;
    else if (lat_po) code_e = FLT_PIN_HI;
    else if (lat_os) code_e = FLT_OUT_SHORT;
    else if (ov_act) code_e = FLT_OVERVOLT;
    else if (ot_act) code_e = FLT_OVERTEMP;
    else             code_e = FLT_NONE;
    code = code_e;
  end

  // R7: program-pin faults stay latched until reset
  assert_pin_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_ps || lat_po) |=> (lat_ps || lat_po));
  // R8: output-short latch holds
  assert_short_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lat_os |=> lat_os);
  // R9: over-voltage releases only after a low flag
  assert_ov_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ov_act) |-> $past(!ov_flag));
  // R10: over-temperature releases only on clear with set low
  assert_ot_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ot_act) |-> $past(ot_clr && !ot_set));
endmodule

// File: rtl/srgate_supervisor.sv
module srgate_supervisor
  import srsup_pkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int THR_LF      = 375,
  parameter int THR_HF      = 190,
  parameter int QUAL_N      = 7,
  parameter int BURST_TICKS = 2400,
  parameter int PIN_TICKS   = 200,
  parameter int SHORT_TICKS = 1600,
  parameter int OV_TICKS    = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_valid,
  output logic             cyc_ready,
  input  logic [LEN_W-1:0] cyc_len,
  input  logic             det_high,
  input  logic             hf_sel,
  input  logic             pin_short,
  input  logic             pin_open,
  input  logic             out_short,
  input  logic             ov_flag,
  input  logic             ot_set,
  input  logic             ot_clr,
  output logic             gate_en,
  output logic             green,
  output logic [2:0]       fault_code
);
  logic accept;

  assign cyc_ready = rst_n;
  assign accept    = cyc_valid && cyc_ready;

  srsup_green #(
    .LEN_W(LEN_W), .THR_LF(THR_LF), .THR_HF(THR_HF),
    .QUAL_N(QUAL_N), .BURST_TICKS(BURST_TICKS)
  ) u_green (
    .clk(clk), .rst_n(rst_n), .cyc_valid(accept), .cyc_len(cyc_len),
    .hf_sel(hf_sel), .det_high(det_high), .green(green)
  );

  srsup_faults #(
    .PIN_TICKS(PIN_TICKS), .SHORT_TICKS(SHORT_TICKS), .OV_TICKS(OV_TICKS)
  ) u_faults (
    .clk(clk), .rst_n(rst_n), .pin_short(pin_short), .pin_open(pin_open),
    .out_short(out_short), .ov_flag(ov_flag), .ot_set(ot_set),
    .ot_clr(ot_clr), .code(fault_code)
  );

  assign gate_en = (fault_code == 3'(FLT_NONE)) && !green;

  // R11: an over-temperature onset never hides an active lower fault
  assert_prio_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault_code) == 3'(FLT_OVERVOLT) && ov_flag && $past(ov_flag))
      |-> (fault_code != 3'(FLT_OVERTEMP)));
endmodule

// File: tb/test_srgate_supervisor.sv
module test_srgate_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 12;
  localparam int BURST = 2400, PIN = 200, SHRT = 1600, OVT = 6000;

  logic clk = 0, rst_n = 0;
  logic cyc_valid = 0, det_high = 0, hf_sel = 0;
  logic [LW-1:0] cyc_len = '0;
  logic pin_short = 0, pin_open = 0, out_short = 0, ov_flag = 0, ot_set = 0, ot_clr = 0;
  logic cyc_ready, gate_en, green;
  logic [2:0] fault_code;

  int checks = 0, errors = 0;

  srgate_supervisor i_srgate_supervisor (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
    .cyc_len(cyc_len), .det_high(det_high), .hf_sel(hf_sel),
    .pin_short(pin_short), .pin_open(pin_open), .out_short(out_short),
    .ov_flag(ov_flag), .ot_set(ot_set), .ot_clr(ot_clr),
    .gate_en(gate_en), .green(green), .fault_code(fault_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int  m_q, m_hi, m_cps, m_cpo, m_cos, m_cov;
  bit  m_green, m_ps, m_po, m_os, m_ov, m_ot;

  task automatic pers(input bit lvl, input int lim, inout int c, output bit f);
    f = 0;
    if (!lvl) c = 0;
    else if (c < lim) begin c++; f = (c == lim); end
  endtask

  function automatic int m_code();
    if (m_ps) return 1;
    if (m_po) return 2;
    if (m_os) return 3;
    if (m_ov) return 4;
    if (m_ot) return 5;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit bf, f1, f2, f3, f4, q;
    int thr;
    if (!rst_n) begin
      m_q = 0; m_hi = 0; m_cps = 0; m_cpo = 0; m_cos = 0; m_cov = 0;
      m_green = 0; m_ps = 0; m_po = 0; m_os = 0; m_ov = 0; m_ot = 0;
    end else begin
      thr = hf_sel ? 190 : 375;
      pers(det_high, BURST, m_hi, bf);
      if (cyc_valid) begin
        q = m_green ? (int'(cyc_len) > thr) : (int'(cyc_len) < thr);
        if (!q) m_q = 0;
        else begin
          m_q++;
          if (m_q == 7) begin m_green = !m_green; m_q = 0; end
        end
      end
      if (bf) begin m_green = 1; m_q = 0; end
      pers(pin_short, PIN, m_cps, f1);
      pers(pin_open, PIN, m_cpo, f2);
      pers(out_short, SHRT, m_cos, f3);
      pers(ov_flag, OVT, m_cov, f4);
      if (f1) m_ps = 1;
      if (f2) m_po = 1;
      if (f3) m_os = 1;
      if (f4) m_ov = 1; else if (!ov_flag) m_ov = 0;
      if (ot_set) m_ot = 1; else if (ot_clr) m_ot = 0;
    end
    #(CLK_PERIOD/4);
    if (rst_n) begin
      check("R2 model green", green, m_green);
      check("R11 model code", fault_code, m_code());
      check("R12 model gate", gate_en, (m_code() == 0 && !m_green));
      check("R12 ready", cyc_ready, 1);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; clks(2); rst_n = 1; clks(1);
  endtask

  task automatic send(input int len);
    cyc_valid = 1; cyc_len = LW'(len); clks(1);
    cyc_valid = 0; clks(1);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clks(1);
    do_reset();
    // R1 reset state
    check("R1 gate_en", gate_en, 1);
    check("R1 green", green, 0);
    check("R1 fault_code", fault_code, 0);
    check("R1 ready", cyc_ready, 1);

    // R4: six short, one equal to threshold, then six short -> no green
    repeat (6) send(300);
    send(375);
    repeat (6) send(300);
    check("R4 equal restarts count", green, 0);
    send(300);
    check("R2 LF entry on seventh", green, 1);
    check("R12 gate off in green", gate_en, 0);

    // R3 exit
    repeat (6) send(500);
    check("R3 six long keeps green", green, 1);
    send(500);
    check("R3 exit on seventh", green, 0);

    // R2 HF threshold
    hf_sel = 1;
    repeat (7) send(250);
    check("R2 HF 250 not below 190", green, 0);
    repeat (7) send(150);
    check("R2 HF entry", green, 1);
    repeat (7) send(250);
    check("R3 HF exit", green, 0);
    hf_sel = 0;

    // R5 burst entry
    det_high = 1; clks(BURST - 1);
    check("R5 one short of timeout", green, 0);
    clks(1);
    check("R5 burst timeout", green, 1);
    det_high = 0; clks(1);

    // R6 burst vs. seventh exit beat on the same edge
    repeat (6) send(500);
    det_high = 1; clks(BURST - 1);
    cyc_valid = 1; cyc_len = LW'(500); clks(1);
    cyc_valid = 0; det_high = 0; clks(1);
    check("R6 burst wins", green, 1);
    repeat (6) send(500);
    check("R5 count cleared by burst", green, 1);
    send(500);
    check("R3 exit after burst", green, 0);

    // R7 pin short: short run ignored, full run latches
    pin_short = 1; clks(PIN - 1); pin_short = 0; clks(1);
    check("R7 short run ignored", fault_code, 0);
    pin_short = 1; clks(PIN);
    check("R7 pin short latched", fault_code, 1);
    check("R12 gate off on fault", gate_en, 0);
    pin_short = 0; clks(3);
    check("R7 latch holds", fault_code, 1);
    pin_open = 1; clks(PIN); pin_open = 0; clks(1);
    check("R11 short beats open", fault_code, 1);
    do_reset();
    check("R7 cleared by reset", fault_code, 0);
    pin_open = 1; clks(PIN); pin_open = 0; clks(2);
    check("R7 pin open latched", fault_code, 2);
    do_reset();

    // R8 output short
    out_short = 1; clks(SHRT - 1);
    check("R8 before debounce", fault_code, 0);
    clks(1);
    check("R8 output short latched", fault_code, 3);
    out_short = 0; ot_set = 1; clks(1); ot_set = 0; clks(1);
    check("R11 short beats overtemp", fault_code, 3);
    do_reset();

    // R9 / R10 / R11
    ov_flag = 1; clks(OVT);
    check("R9 over-voltage set", fault_code, 4);
    ot_set = 1; clks(1); ot_set = 0; clks(1);
    check("R11 overvolt beats overtemp", fault_code, 4);
    ov_flag = 0; clks(1);
    check("R9 release shows overtemp", fault_code, 5);
    ot_set = 1; ot_clr = 1; clks(1);
    check("R10 clear ignored while set", fault_code, 5);
    ot_set = 0; clks(1); ot_clr = 0;
    check("R10 released", fault_code, 0);
    check("R12 gate back on", gate_en, 1);
    ot_set = 1; clks(1); ot_set = 0;
    check("R10 set next edge", fault_code, 5);
    clks(5);
    check("R10 holds without clear", fault_code, 5);
    ot_clr = 1; clks(1); ot_clr = 0; clks(1);
    check("R10 final clear", fault_code, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule